// File: doc/BRIEF.md
# Interrupt Priority Register File

This block holds one 8-bit priority value for every shared interrupt and makes it reachable over a simple register port. An access selects an interrupt index with `addr`. It is either a single byte, which touches one interrupt, or a 32-bit word, which covers the four interrupts of an aligned group of four. Read data is registered and appears one cycle after the access is presented. A write takes effect at the same clock edge that captures the read.

Each access carries a secure attribute. When an access is non-secure and the global security-disable input is low, the block applies a restricted view. Interrupts configured as group 0 are hidden from that view. Priorities of group-1 interrupts are seen and written through a half-range mapping that keeps the upper half of the priority space for them. Secure accesses, and every access while security is disabled, see and write the stored bytes unchanged. Interrupt indices below 32 are reserved for per-core interrupts and have no storage here. Indices at or above the implemented count also have no storage.

Top module: `prio_regfile`

## Requirements
- R1: Every implemented interrupt from 32 to NUM_IRQ-1 holds an 8-bit priority that resets to 0x00. Read data is registered: an access presented in one cycle shows its result on `rdata` after the next rising clock edge, and that result reflects storage as it stood before any write in the same access.
- R2: A byte access (`size_word`=0) targets interrupt `addr`. A read returns the view of that interrupt in `rdata[7:0]` with `rdata[31:8]` zero, and a write uses `wdata[7:0]`.
- R3: A word access (`size_word`=1) ignores `addr[1:0]` and covers interrupts base..base+3, where base is `addr` with its two low bits cleared. Interrupt base+k maps to byte lane k, bits 8k+7:8k, so the lowest index sits in bits 7:0.
- R4: An access is restricted when `secure`=0 and `sec_disable`=0. In a restricted access, an interrupt whose `group_bits` entry is 0 (group 0) reads as 0x00, and a write to it leaves its stored value unchanged.
- R5: A restricted read of a group-1 interrupt returns the stored value shifted left by one bit and truncated to 8 bits.
- R6: A restricted write to a group-1 interrupt stores 0x80 OR the written byte shifted right by one bit.
- R7: When `secure`=1 or `sec_disable`=1, reads return the stored byte and writes store the written byte unchanged, whatever the group bit.
- R8: Interrupts below 32 or at or above NUM_IRQ read as 0x00 in their lane, and writes to them have no effect.
- R9: A word write is dropped as a whole, leaving all four lanes untouched, when base is below 32 or base+3 is at or above NUM_IRQ.
- R10: An accepted word write updates all four interrupts at one clock edge. The group check and mapping of R4 to R6 are applied to each lane separately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | IDX_W | Interrupt index of the access (word accesses ignore bits 1:0) |
| size_word | input | 1 | 1 = 32-bit word access over four interrupts, 0 = byte access |
| wdata | input | 32 | Write data; byte accesses use bits 7:0 |
| wen | input | 1 | Write enable for the access presented this cycle |
| secure | input | 1 | Secure attribute of the access |
| group_bits | input | NUM_IRQ-32 | Group of interrupt 32+j at bit j; 1 = group 1, 0 = group 0 |
| sec_disable | input | 1 | Global security-disable; 1 gives every access the full view |
| rdata | output | 32 | Registered read data of the previous cycle's access |

## Verification
Every access yields exactly one result: the read view appears on `rdata` one rising edge after the access is driven. A write lands at that same edge, so a read of the written interrupt must be a separate access that shows the new value one edge later. The bench drives each access on the falling edge and computes the expected word from its model before applying the write. It then compares `rdata` one time unit after the following rising edge, and only after that updates the model. This keeps the read-before-write ordering of R1 explicit in every comparison, including back-to-back write then read pairs.

// File: rtl/prio_regfile.sv
module prio_regfile #(
  parameter int NUM_IRQ = 96,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   addr,
  input  logic               size_word,
  input  logic [31:0]        wdata,
  input  logic               wen,
  input  logic               secure,
  input  logic [NUM_IRQ-33:0] group_bits,
  input  logic               sec_disable,
  output logic [31:0]        rdata
);
  localparam int SPI_N = NUM_IRQ - 32;
  localparam int SW    = (SPI_N > 1) ? $clog2(SPI_N) : 1;
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(32);

  logic             restricted;
  logic [IDX_W-1:0] base;
  logic             word_ok;
  logic [8*SPI_N-1:0] flat;
  logic [31:0]      rd_next;

  assign restricted = !secure && !sec_disable;
  assign base       = {addr[IDX_W-1:2], 2'b00};
  assign word_ok    = (int'(base) >= 32) && (int'(base) + 3 < NUM_IRQ);

  for (genvar j = 0; j < SPI_N; j++) begin : g_ent
    localparam int IRQ = j + 32;
    logic       hit;
    logic [7:0] din;
    logic [7:0] q;

    assign hit = wen && (size_word ? (word_ok && int'(addr[IDX_W-1:2]) == IRQ / 4)
                                   : (int'(addr) == IRQ));
    assign din = size_word ? wdata[8*(IRQ%4) +: 8] : wdata[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= 8'h00;
      else if (hit && (!restricted || group_bits[j]))
        q <= restricted ? (8'h80 | (din >> 1)) : din;
    end

    assign flat[8*j +: 8] = q;
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic [SW-1:0]    off;
    logic             valid;
    logic [7:0]       p;
    logic             g;

    assign idx   = size_word ? {addr[IDX_W-1:2], 2'(k)} : addr;
    assign off   = SW'(idx - FIRST);
    assign valid = (size_word || k == 0) && (int'(idx) >= 32) && (int'(idx) < NUM_IRQ);
    assign p     = flat[8*int'(off) +: 8];
    assign g     = group_bits[off];

    assign rd_next[8*k +: 8] = !valid    ? 8'h00 :
                               restricted ? (g ? {p[6:0], 1'b0} : 8'h00) : p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= 32'h0;
    else
      rdata <= rd_next;
  end
endmodule

// File: rtl/prio_regfile_chk.sv
module prio_regfile_chk #(
  parameter int NUM_IRQ = 96,
  parameter int IDX_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IDX_W-1:0]   addr,
  input logic               size_word,
  input logic [31:0]        wdata,
  input logic               wen,
  input logic               secure,
  input logic [NUM_IRQ-33:0] group_bits,
  input logic               sec_disable,
  input logic [31:0]        rdata
);
  logic rstr;
  logic byte_ok;
  assign rstr    = !secure && !sec_disable;
  assign byte_ok = !size_word && int'(addr) >= 32 && int'(addr) < NUM_IRQ;

  assert_low_range_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) < 32) |=> (rdata == 32'h0));

  assert_high_range_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!size_word && int'(addr) >= NUM_IRQ) |=> (rdata == 32'h0));

  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !size_word |=> (rdata[31:8] == 24'h0));

  assert_hidden_group0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && rstr && !group_bits[int'(addr) - 32]) |=> (rdata == 32'h0));

  assert_shift_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && rstr) |=> (rdata[0] == 1'b0));

  assert_full_write_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !rstr && !wen && $past(byte_ok && !rstr && wen) && addr == $past(addr))
      |=> (rdata[7:0] == $past(wdata[7:0], 2)));

  assert_restricted_write_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !rstr && !wen && $past(byte_ok && rstr && wen && group_bits[int'(addr) - 32])
      && addr == $past(addr))
      |=> (rdata[7] == 1'b1));
endmodule

bind prio_regfile prio_regfile_chk #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_prio_regfile.sv
`timescale 1ns/1ps
module sim_prio_regfile;
  localparam int NUM_IRQ = 94;
  localparam int IDX_W   = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [IDX_W-1:0]   addr = '0;
  logic               size_word = 1'b0;
  logic [31:0]        wdata = '0;
  logic               wen = 1'b0;
  logic               secure = 1'b1;
  logic [NUM_IRQ-33:0] grp = '0;
  logic               sec_disable = 1'b0;
  logic [31:0]        rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [NUM_IRQ];

  always #2 clk = ~clk;

  prio_regfile #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size_word(size_word), .wdata(wdata),
    .wen(wen), .secure(secure), .group_bits(grp), .sec_disable(sec_disable), .rdata(rdata));

  function automatic logic [7:0] lane_view(int idx, bit sec, bit sd);
    if (idx < 32 || idx >= NUM_IRQ) return 8'h00;
    if (!sec && !sd) return grp[idx-32] ? {mdl[idx][6:0], 1'b0} : 8'h00;
    return mdl[idx];
  endfunction

  function automatic logic [31:0] exp_read(int a, bit w, bit sec, bit sd);
    logic [31:0] r = '0;
    if (w) begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = lane_view((a & ~3) + k, sec, sd);
    end else r[7:0] = lane_view(a, sec, sd);
    return r;
  endfunction

  function automatic void put(int idx, logic [7:0] v, bit sec, bit sd);
    if (idx < 32 || idx >= NUM_IRQ) return;
    if (!sec && !sd) begin
      if (grp[idx-32]) mdl[idx] = 8'h80 | (v >> 1);
    end else mdl[idx] = v;
  endfunction

  function automatic void apply_write(int a, bit w, logic [31:0] d, bit sec, bit sd);
    if (w) begin
      int b = a & ~3;
      if (b < 32 || b + 3 >= NUM_IRQ) return;
      for (int k = 0; k < 4; k++) put(b + k, d[8*k +: 8], sec, sd);
    end else put(a, d[7:0], sec, sd);
  endfunction

  task automatic acc(int a, bit w, bit we, logic [31:0] d, bit sec, bit sd, string tag);
    logic [31:0] e;
    @(negedge clk);
    addr = IDX_W'(a); size_word = w; wen = we; wdata = d; secure = sec; sec_disable = sd;
    e = exp_read(a, w, sec, sd);
    @(posedge clk);
    #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s addr=%0d word=%0b sec=%0b sd=%0b actual=%h expected=%h",
               tag, a, w, sec, sd, rdata, e);
    end
    if (we) apply_write(a, w, d, sec, sd);
    wen = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NUM_IRQ; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    acc(32, 1, 0, 0, 1, 0, "R1 reset");
    acc(60, 1, 0, 0, 1, 0, "R1 reset");
    grp = '1;
    acc(40, 0, 1, 32'hFFFF_FF5A, 1, 0, "R2 write");
    acc(40, 0, 0, 0, 1, 0, "R2 byte read");
    acc(41, 1, 0, 0, 1, 0, "R3 word lane0");
    acc(44, 1, 1, 32'h4433_2211, 1, 0, "R10 word write");
    acc(46, 1, 0, 0, 1, 0, "R3 word packing");
    acc(46, 0, 0, 0, 1, 0, "R3 byte lane");
    acc(40, 0, 0, 0, 0, 0, "R5 shifted read");
    acc(40, 0, 1, 32'h0000_0031, 0, 0, "R6 restricted write");
    acc(40, 0, 0, 0, 1, 0, "R6 stored value");
    grp[48-32] = 1'b0;
    acc(48, 1, 1, 32'hAABB_CCDD, 1, 0, "R7 secure word");
    acc(48, 1, 1, 32'h1122_3344, 0, 0, "R10 per-lane group");
    acc(48, 1, 0, 0, 1, 0, "R10 lanes after");
    acc(48, 0, 0, 0, 0, 0, "R4 hidden read");
    acc(48, 0, 1, 32'h0000_0077, 0, 0, "R4 dropped write");
    acc(48, 0, 0, 0, 1, 0, "R4 value kept");
    acc(48, 0, 1, 32'h0000_0077, 0, 1, "R7 disable write");
    acc(48, 0, 0, 0, 0, 1, "R7 disable read");
    acc(92, 1, 1, 32'h5555_5555, 1, 0, "R9 partial word");
    acc(92, 0, 0, 0, 1, 0, "R9 lane kept");
    acc(92, 1, 0, 0, 1, 0, "R8 partial read");
    acc(28, 1, 1, 32'hFFFF_FFFF, 1, 0, "R9 low word");
    acc(31, 0, 1, 32'h0000_00FF, 1, 0, "R8 low write");
    acc(31, 0, 0, 0, 1, 0, "R8 low read");
    acc(95, 0, 1, 32'h0000_00FF, 1, 0, "R8 high write");
    acc(95, 0, 0, 0, 1, 0, "R8 high read");

    for (int i = 0; i < 4000; i++) begin
      int a;
      bit w, we, sec, sd;
      string tag;
      if (i % 200 == 0) grp = {$urandom, $urandom};
      a   = (i % 50 == 7) ? int'($urandom_range(0, 1023)) : int'($urandom_range(0, NUM_IRQ + 7));
      w   = $urandom_range(0, 1) == 1;
      we  = $urandom_range(0, 2) == 0;
      sec = $urandom_range(0, 1) == 1;
      sd  = $urandom_range(0, 4) == 0;
      if (a < 32 || a >= NUM_IRQ) tag = "R8 random";
      else if (!sec && !sd) tag = "R5 random";
      else tag = "R7 random";
      acc(a, w, we, $urandom, sec, sd, tag);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule